// File: doc/BRIEF.md
# 1-Wire Link-Layer Bus Monitor

This block listens, without ever driving it, to a sampled single-wire bus and sorts every low pulse on the line into one of three link-level events. These are a data bit slot, a reset pulse, and a presence answer sent back by a device after a reset. It runs on one fixed sample clock. All timing is measured in cycles of that clock. The three event kinds reach the next protocol layer as one-cycle strobes with a qualifier bit each.

The raw line goes through a two-flop synchronizer. A falling edge starts a slot and restarts a shared saturating timer. The bit value is the line level a fixed count after the fall. A slot whose bit reads 0 is timed until the line rises again. That low time decides whether the pulse was a normal reset, an overdrive reset or an ordinary slot. After a reset, the line is sampled once more a fixed count after the rise, to see whether a device holds it low.

Two speed modes are supported. The overdrive flag is set by a one-cycle strobe from the network layer above. It is cleared by the block reset and by any normal-length bus reset. Six parameters give the bit, presence and reset thresholds for each mode.

Top module: `owire_link_monitor`

## Requirements
- R1: A falling edge on `bus_in` produces exactly one `bit_valid` pulse, one cycle wide, BIT+3 cycles after the first low cycle of the input. BIT is `T_BIT_N` in normal mode and `T_BIT_O` in overdrive mode. `bit_value` is 0 when the pulse lasted more than BIT cycles and 1 otherwise.
- R2: A slot whose bit reads 1 returns the monitor to idle. It produces no reset and no presence event.
- R3: For a slot whose bit reads 0, the low time is the number of cycles the input stayed low. If that time exceeds `T_RST_N`, `rst_strobe` pulses one cycle, 3 cycles after the first high input cycle, with `rst_is_od` = 0. A low time of exactly `T_RST_N` gives no reset.
- R4: In overdrive mode, a low time above `T_RST_O` that does not exceed `T_RST_N` gives `rst_strobe` with `rst_is_od` = 1. A low time of exactly `T_RST_O` gives no reset. In normal mode such pulses are plain data slots.
- R5: After a reset, `pres_strobe` pulses one cycle, PRES+3 cycles after the first high input cycle. PRES is `T_PRES_N` after a normal reset and `T_PRES_O` after an overdrive reset. `pres_found` is 1 when the input was low PRES cycles after the rise, and 0 otherwise.
- R6: When a presence is found, the device's low pulse that follows produces no `bit_valid`, `rst_strobe` or second `pres_strobe`.
- R7: A one-cycle high on `od_set` selects overdrive mode. A normal reset returns the block to normal mode, and so does `rst`.
- R8: The timer saturates. A low pulse much longer than the timer range is still reported as a normal reset.
- R9: While and right after `rst` is high, all three strobes are 0. All three qualifiers are also 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Raw bus line level, idle high |
| od_set | input | 1 | One-cycle strobe that selects overdrive mode |
| bit_valid | output | 1 | One-cycle strobe, a data bit was sampled |
| bit_value | output | 1 | Value of the last sampled bit |
| rst_strobe | output | 1 | One-cycle strobe, a reset pulse ended |
| rst_is_od | output | 1 | Last reset was of overdrive length |
| pres_strobe | output | 1 | One-cycle strobe, presence window sampled |
| pres_found | output | 1 | Last presence sample found a device |

## Verification
The hardest states to reach are the corners of the overdrive mode. An overdrive reset can only occur after the mode strobe. A normal reset or the block reset must then silently leave that mode, and that can only be seen by how a later 60-cycle pulse is classified. The stimulus table therefore orders its entries so that a mode set is followed first by overdrive slots, then by a normal reset, and then by a probe pulse. A second entry sets the mode and then applies the block reset before the probe. The presence path is reached by shaping a second low pulse after each reset so that it either covers or misses the sample point. A 1200-cycle pulse overruns the timer width to exercise saturation.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BIT  = 2'd1,
    ST_RISE = 2'd2,
    ST_PRES = 2'd3
  } owm_state_t;

  function automatic int owm_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/owm_timer.sv
module owm_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mark,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (mark)        cnt <= CW'(1);
    else if (cnt != '1)   cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/owm_mode.sv
module owm_mode (
  input  logic clk,
  input  logic rst,
  input  logic set_od,
  input  logic clr_od,
  output logic od
);
  always_ff @(posedge clk) begin
    if (rst)         od <= 1'b0;
    else if (clr_od) od <= 1'b0;
    else if (set_od) od <= 1'b1;
  end
endmodule

// File: rtl/owm_fsm.sv
module owm_fsm
  import owm_pkg::*;
#(
  parameter int CW       = 9,
  parameter int T_BIT_N  = 14,
  parameter int T_PRES_N = 74,
  parameter int T_RST_N  = 479,
  parameter int T_BIT_O  = 1,
  parameter int T_PRES_O = 9,
  parameter int T_RST_O  = 47
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lvl,
  input  logic [CW-1:0] cnt,
  input  logic          od,
  output logic          mark,
  output logic          clr_od,
  output logic          bit_valid,
  output logic          bit_value,
  output logic          rst_strobe,
  output logic          rst_is_od,
  output logic          pres_strobe,
  output logic          pres_found
);
  owm_state_t st, nxt;
  logic [CW-1:0] th_bit, th_pres;
  logic ev_bit, ev_rst, ev_rst_od, ev_pres;

  assign th_bit  = od ? CW'(T_BIT_O)  : CW'(T_BIT_N);
  assign th_pres = od ? CW'(T_PRES_O) : CW'(T_PRES_N);

  always_comb begin
    nxt       = st;
    mark      = 1'b0;
    clr_od    = 1'b0;
    ev_bit    = 1'b0;
    ev_rst    = 1'b0;
    ev_rst_od = 1'b0;
    ev_pres   = 1'b0;
    case (st)
      ST_IDLE: begin
        if (!lvl) begin
          nxt  = ST_BIT;
          mark = 1'b1;
        end
      end
      ST_BIT: begin
        if (cnt == th_bit) begin
          ev_bit = 1'b1;
          nxt    = lvl ? ST_IDLE : ST_RISE;
        end
      end
      ST_RISE: begin
        if (lvl) begin
          if (cnt > CW'(T_RST_N)) begin
            ev_rst = 1'b1;
            clr_od = 1'b1;
            mark   = 1'b1;
            nxt    = ST_PRES;
          end else if (od && (cnt > CW'(T_RST_O))) begin
            ev_rst    = 1'b1;
            ev_rst_od = 1'b1;
            mark      = 1'b1;
            nxt       = ST_PRES;
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      ST_PRES: begin
        if (cnt == th_pres) begin
          ev_pres = 1'b1;
          if (!lvl) begin
            mark = 1'b1;
            nxt  = ST_RISE;
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      bit_valid   <= 1'b0;
      bit_value   <= 1'b0;
      rst_strobe  <= 1'b0;
      rst_is_od   <= 1'b0;
      pres_strobe <= 1'b0;
      pres_found  <= 1'b0;
    end else begin
      st          <= nxt;
      bit_valid   <= ev_bit;
      rst_strobe  <= ev_rst;
      pres_strobe <= ev_pres;
      if (ev_bit)  bit_value  <= lvl;
      if (ev_rst)  rst_is_od  <= ev_rst_od;
      if (ev_pres) pres_found <= !lvl;
    end
  end
endmodule

// File: rtl/owire_link_monitor.sv
module owire_link_monitor
  import owm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int T_BIT_N     = 14,
  parameter int T_PRES_N    = 74,
  parameter int T_RST_N     = 479,
  parameter int T_BIT_O     = 1,
  parameter int T_PRES_O    = 9,
  parameter int T_RST_O     = 47
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_in,
  input  logic od_set,
  output logic bit_valid,
  output logic bit_value,
  output logic rst_strobe,
  output logic rst_is_od,
  output logic pres_strobe,
  output logic pres_found
);
  localparam int T_MAX = owm_max3(owm_max3(T_BIT_N, T_PRES_N, T_RST_N),
                                  owm_max3(T_BIT_O, T_PRES_O, T_RST_O), 1);
  localparam int CW    = $clog2(T_MAX + 2);

  logic          lvl;
  logic          mark;
  logic          clr_od;
  logic          od_q;
  logic [CW-1:0] cnt;

  owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (bus_in),
    .dout (lvl)
  );

  owm_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .mark (mark),
    .cnt  (cnt)
  );

  owm_mode u_mode (
    .clk    (clk),
    .rst    (rst),
    .set_od (od_set),
    .clr_od (clr_od),
    .od     (od_q)
  );

  owm_fsm #(
    .CW(CW), .T_BIT_N(T_BIT_N), .T_PRES_N(T_PRES_N), .T_RST_N(T_RST_N),
    .T_BIT_O(T_BIT_O), .T_PRES_O(T_PRES_O), .T_RST_O(T_RST_O)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .lvl         (lvl),
    .cnt         (cnt),
    .od          (od_q),
    .mark        (mark),
    .clr_od      (clr_od),
    .bit_valid   (bit_valid),
    .bit_value   (bit_value),
    .rst_strobe  (rst_strobe),
    .rst_is_od   (rst_is_od),
    .pres_strobe (pres_strobe),
    .pres_found  (pres_found)
  );
endmodule

// File: rtl/owm_checker.sv
module owm_checker (
  input logic clk,
  input logic rst,
  input logic bit_valid,
  input logic rst_strobe,
  input logic rst_is_od,
  input logic pres_strobe,
  input logic pres_found,
  input logic od_q
);
  // R1
  bit_strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);

  // R3
  rst_strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    rst_strobe |=> !rst_strobe);

  // R5
  pres_strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    pres_strobe |=> !pres_strobe);

  // R6
  one_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bit_valid, rst_strobe, pres_strobe}));

  // R4
  od_reset_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_strobe && rst_is_od) |-> $past(od_q));

  // R7
  normal_reset_clears_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_strobe && !rst_is_od) |-> !od_q);

  // R9
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(bit_valid || rst_strobe || pres_strobe || pres_found || od_q));
endmodule

bind owire_link_monitor owm_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .bit_valid   (bit_valid),
  .rst_strobe  (rst_strobe),
  .rst_is_od   (rst_is_od),
  .pres_strobe (pres_strobe),
  .pres_found  (pres_found),
  .od_q        (od_q)
);

// File: tb/owire_link_monitor_tb.sv
`timescale 1ns/1ps
module owire_link_monitor_tb;
  localparam int TBN = 14, TPN = 74, TRN = 479;
  localparam int TBO = 1,  TPO = 9,  TRO = 47;
  localparam int TAIL = 100;

  typedef struct packed {
    logic [1:0]  pre;   // 0 none, 1 od_set strobe, 2 block reset
    logic [11:0] low1;
    logic [11:0] high1;
    logic [11:0] low2;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 12'd3,    12'd0,   12'd0},
    '{2'd0, 12'd14,   12'd0,   12'd0},
    '{2'd0, 12'd15,   12'd0,   12'd0},
    '{2'd0, 12'd60,   12'd0,   12'd0},
    '{2'd0, 12'd479,  12'd0,   12'd0},
    '{2'd0, 12'd480,  12'd100, 12'd0},
    '{2'd0, 12'd500,  12'd20,  12'd120},
    '{2'd1, 12'd60,   12'd4,   12'd10},
    '{2'd0, 12'd1,    12'd0,   12'd0},
    '{2'd0, 12'd2,    12'd0,   12'd0},
    '{2'd0, 12'd47,   12'd0,   12'd0},
    '{2'd0, 12'd48,   12'd4,   12'd10},
    '{2'd0, 12'd500,  12'd90,  12'd0},
    '{2'd0, 12'd60,   12'd0,   12'd0},
    '{2'd1, 12'd2,    12'd0,   12'd0},
    '{2'd2, 12'd60,   12'd0,   12'd0},
    '{2'd0, 12'd1200, 12'd100, 12'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_in = 1'b1;
  logic od_set = 1'b0;
  logic bit_valid, bit_value, rst_strobe, rst_is_od, pres_strobe, pres_found;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit od_m = 1'b0;

  always #5 clk = ~clk;

  owire_link_monitor #(
    .T_BIT_N(TBN), .T_PRES_N(TPN), .T_RST_N(TRN),
    .T_BIT_O(TBO), .T_PRES_O(TPO), .T_RST_O(TRO)
  ) u_dut (
    .clk(clk), .rst(rst), .bus_in(bus_in), .od_set(od_set),
    .bit_valid(bit_valid), .bit_value(bit_value),
    .rst_strobe(rst_strobe), .rst_is_od(rst_is_od),
    .pres_strobe(pres_strobe), .pres_found(pres_found)
  );

  task automatic chk(input string req, input int v, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s vec %0d: actual %0d expected %0d", req, v, act, exp);
    end
  endtask

  task automatic check_quiet(input string req);
    chk(req, -1, int'({bit_valid, rst_strobe, pres_strobe}), 0);
    chk(req, -1, int'({bit_value, rst_is_od, pres_found}), 0);
  endtask

  task automatic run_vec(input int v, input vec_t t);
    int tb_, tp_, total;
    int e_nb, e_bv, e_boff, e_nr, e_rod, e_roff, e_np, e_pf, e_poff;
    int nb, bv, boff, nr, rod, roff, np, pf, poff;
    int l1, h1, l2;
    l1 = int'(t.low1); h1 = int'(t.high1); l2 = int'(t.low2);
    if (t.pre == 2'd1) begin
      @(negedge clk) od_set = 1'b1;
      @(negedge clk) od_set = 1'b0;
      od_m = 1'b1;
    end else if (t.pre == 2'd2) begin
      @(negedge clk) rst = 1'b1;
      @(negedge clk);
      @(negedge clk) rst = 1'b0;
      check_quiet("R9");
      od_m = 1'b0;
      repeat (4) @(negedge clk);
    end
    // expected values from the requirements
    tb_ = od_m ? TBO : TBN;
    e_nb = 1; e_boff = tb_ + 3;
    e_bv = (l1 > tb_) ? 0 : 1;
    e_nr = 0; e_rod = 0; e_roff = 0; e_np = 0; e_pf = 0; e_poff = 0;
    if (l1 > tb_) begin
      if (l1 > TRN) begin
        e_nr = 1; e_rod = 0; od_m = 1'b0; tp_ = TPN;
      end else if (od_m && l1 > TRO) begin
        e_nr = 1; e_rod = 1; tp_ = TPO;
      end else tp_ = 0;
      if (e_nr == 1) begin
        e_roff = l1 + 3;
        e_np = 1; e_poff = l1 + 3 + tp_;
        e_pf = (tp_ >= h1 && tp_ < h1 + l2) ? 1 : 0;
      end
    end
    total = l1 + h1 + l2 + TAIL;
    nb = 0; bv = -1; boff = -1; nr = 0; rod = -1; roff = -1;
    np = 0; pf = -1; poff = -1;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      if (bit_valid)   begin nb++; if (nb == 1) begin bv = bit_value;  boff = i; end end
      if (rst_strobe)  begin nr++; if (nr == 1) begin rod = rst_is_od; roff = i; end end
      if (pres_strobe) begin np++; if (np == 1) begin pf = pres_found; poff = i; end end
      bus_in = ((i < l1) || ((i >= l1 + h1) && (i < l1 + h1 + l2))) ? 1'b0 : 1'b1;
    end
    chk("R1 bit count", v, nb, e_nb);
    chk("R1 bit value", v, bv, e_bv);
    chk("R1 bit timing", v, boff, e_boff);
    if (e_bv == 1) chk("R2 no reset after 1", v, nr + np, 0);
    if (e_nr == 1 && e_rod == 0) begin
      chk("R3 normal reset", v, nr, 1);
      chk("R3 reset flag", v, rod, 0);
      chk("R3 reset timing", v, roff, e_roff);
    end else if (e_nr == 1) begin
      chk("R4 od reset", v, nr, 1);
      chk("R4 reset flag", v, rod, 1);
      chk("R4 reset timing", v, roff, e_roff);
    end else begin
      chk("R3 R4 no reset", v, nr, 0);
    end
    chk("R5 presence count", v, np, e_np);
    if (e_np == 1) begin
      chk("R5 presence flag", v, pf, e_pf);
      chk("R5 presence timing", v, poff, e_poff);
    end
    if (e_pf == 1) chk("R6 presence pulse not a slot", v, nb, 1);
    if (l1 >= 1000) chk("R8 saturated reset", v, nr, 1);
    if (v == 13 || v == 15) chk("R7 back in normal mode", v, boff, TBN + 3);
    if (v == 8 || v == 14) chk("R7 overdrive timing", v, boff, TBO + 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_quiet("R9");
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check_quiet("R9");
    for (int v = 0; v < NV; v++) run_vec(v, VECS[v]);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule